// File: doc/BRIEF.md
# Bus Register Slave with One-Wait-State Acknowledge

This block is a small memory-mapped register slave for a classic synchronous shared bus with cycle, strobe, write-enable, word address, write data and per-byte selects. It holds a bank of 32-bit control registers. Every transfer completes after exactly one wait state. The acknowledge is registered from the bus clock, which is the only clock the block uses.

The acknowledge is produced from cycle and strobe together, masked by its own current value. This gives two properties. First, the acknowledge falls right after the completing edge, so it never lingers while strobe is being released. Second, a master that holds cycle and strobe high across many clocks sees the acknowledge pulse on alternate cycles. Each pulse completes one transfer at the address presented at that moment, so the master can step through registers within one long cycle by changing the address after each acknowledge.

Writes land on the edge at which the acknowledge is high, once per transfer, lane by lane under the byte selects. Reads show the addressed register on the output bus while the acknowledge is high, and zero at all other times.

Top module: `wbs_regbank`

## Requirements
- R1: When cycle and strobe are both sampled high at a clock edge while acknowledge is low, acknowledge is high in the following cycle. The cycle in which the request first appears (the wait state) has acknowledge low.
- R2: Acknowledge is never high in two consecutive cycles.
- R3: If strobe is sampled low at an edge, acknowledge is low in the following cycle.
- R4: With cycle and strobe held high, acknowledge alternates low and high. Each high cycle completes one transfer at the address presented in that cycle, so consecutive reads or writes to different addresses are served within one cycle.
- R5: A write takes effect on the edge where acknowledge, cycle, strobe and write-enable are all high. Byte lane k (data bits 8k+7..8k) is updated only when select bit k is 1, and each transfer writes once.
- R6: While acknowledge is high, the read-data output carries the register at the presented word address. While acknowledge is low, it is zero.
- R7: Reset is synchronous and active low. It clears acknowledge and all registers to zero.
- R8: With cycle low, acknowledge stays low even if strobe is high, and no register changes.
- R9: Four registers sit at word addresses 0 to 3. Any other address is still acknowledged. It reads as zero, and a write to it changes no register.
- R10: If strobe is raised and dropped again before any clock edge samples it, no acknowledge is issued and no write takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| cyc_i | input | 1 | Bus cycle in progress |
| stb_i | input | 1 | Transfer strobe |
| we_i | input | 1 | Write enable (1 = write) |
| adr_i | input | ADDR_W (4) | Word address |
| dat_i | input | DATA_W (32) | Write data |
| sel_i | input | DATA_W/8 (4) | Byte lane selects |
| dat_o | output | DATA_W (32) | Read data, zero unless acknowledged |
| ack_o | output | 1 | Transfer acknowledge |

## Verification
The hardest situation to produce at the ports is a long cycle. In it, cycle and strobe stay high over many clocks while the address and data change only in the low phase that follows each acknowledge. A faulty acknowledge would either stretch or double-complete here, and a stale address would land in the wrong register. The stimulus holds both control lines high through read and write runs that cover every address. At every falling edge it checks the alternating acknowledge pattern, and it uses read-back to show that each pulse wrote exactly one word under the lane selects. It also provokes a strobe glitch between two edges, and strobe held without cycle, to show that neither leaves a mark.

// File: rtl/wbs_pkg.sv
// Package: shared constants and helpers for the register slave.
// Assumes data widths are whole multiples of a byte.
package wbs_pkg;

    // Width of one byte lane.
    localparam int unsigned LANE_W = 8;

    // Default geometry of the register bank.
    localparam int unsigned DEF_DATA_W = 32;
    localparam int unsigned DEF_ADDR_W = 4;
    localparam int unsigned DEF_NREGS  = 4;

    // Transfer phase as seen by the acknowledge generator.
    typedef enum logic [1:0] {
        PH_IDLE = 2'b00,
        PH_WAIT = 2'b01,
        PH_DONE = 2'b10
    } xfer_phase_e;

endpackage

// File: rtl/wbs_ack_gen.sv
// Module: acknowledge generator.
// Produces a registered acknowledge one edge after cycle and strobe are
// both seen high, masked by its own current value so it never holds for
// two cycles. Also flags the completing cycle for the write path.
// Assumes a single clock and a synchronous active-low reset.
module wbs_ack_gen
    import wbs_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        cyc_i,
    input  logic        stb_i,
    output logic        ack_o,
    output logic        done_o,
    output xfer_phase_e phase_o
);

    logic ack_q;
    logic req;

    // Request present on the bus.
    assign req = cyc_i & stb_i;

    // Registered acknowledge, masked by itself to give one-cycle pulses.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ack_q <= 1'b0;
        end else begin
            ack_q <= req & ~ack_q;
        end
    end

    // Transfer completes on the edge closing an acknowledged cycle.
    assign done_o = ack_q & req;
    assign ack_o  = ack_q;

    // Phase report for the read and write paths.
    always_comb begin
        if (ack_q)    phase_o = PH_DONE;
        else if (req) phase_o = PH_WAIT;
        else          phase_o = PH_IDLE;
    end

endmodule

// File: rtl/wbs_addr_dec.sv
// Module: word address decoder.
// Turns the word address into a one-hot register select. Addresses beyond
// the bank give an all-zero select. Assumes NREGS <= 2**ADDR_W.
module wbs_addr_dec #(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned NREGS  = 4
) (
    input  logic [ADDR_W-1:0] adr_i,
    output logic [NREGS-1:0]  hit_o
);

    // One comparator per register.
    for (genvar i = 0; i < NREGS; i++) begin : g_cmp
        assign hit_o[i] = (adr_i == ADDR_W'(i));
    end

endmodule

// File: rtl/wbs_reg_bank.sv
// Module: register storage with byte-lane writes.
// Each register is split into byte lanes. A lane loads only when the write
// strobe, its register select and its byte select are all high.
// Assumes a single clock and a synchronous active-low reset.
module wbs_reg_bank
    import wbs_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned NREGS  = 4
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic                          wr_i,
    input  logic [NREGS-1:0]              hit_i,
    input  logic [DATA_W/LANE_W-1:0]      sel_i,
    input  logic [DATA_W-1:0]             dat_i,
    output logic [NREGS-1:0][DATA_W-1:0]  regs_o
);

    localparam int unsigned LANES = DATA_W / LANE_W;

    for (genvar r = 0; r < NREGS; r++) begin : g_reg
        for (genvar b = 0; b < LANES; b++) begin : g_lane
            logic [LANE_W-1:0] lane_q;

            // Load one byte lane of one register on a selected write.
            always_ff @(posedge clk_i) begin
                if (!rst_ni) begin
                    lane_q <= '0;
                end else if (wr_i && hit_i[r] && sel_i[b]) begin
                    lane_q <= dat_i[b*LANE_W +: LANE_W];
                end
            end

            assign regs_o[r][b*LANE_W +: LANE_W] = lane_q;
        end
    end

endmodule

// File: rtl/wbs_read_mux.sv
// Module: read-data multiplexer.
// AND-OR selection of the addressed register, forced to zero unless the
// acknowledge is high. A zero select (unmapped address) reads as zero.
module wbs_read_mux #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned NREGS  = 4
) (
    input  logic                          ack_i,
    input  logic [NREGS-1:0]              hit_i,
    input  logic [NREGS-1:0][DATA_W-1:0]  regs_i,
    output logic [DATA_W-1:0]             dat_o
);

    // Gather the selected register, then gate by acknowledge.
    always_comb begin
        logic [DATA_W-1:0] acc;
        acc = '0;
        for (int i = 0; i < NREGS; i++) begin
            acc = acc | (regs_i[i] & {DATA_W{hit_i[i]}});
        end
        dat_o = ack_i ? acc : '0;
    end

endmodule

// File: rtl/wbs_regbank.sv
// Module: top of the bus register slave.
// Answers each transfer after one wait state, writes on the acknowledged
// edge and drives read data only while acknowledging. Driven solely by the
// bus clock; reset is synchronous and active low.
module wbs_regbank
    import wbs_pkg::*;
#(
    parameter int unsigned DATA_W = DEF_DATA_W,
    parameter int unsigned ADDR_W = DEF_ADDR_W,
    parameter int unsigned NREGS  = DEF_NREGS
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       cyc_i,
    input  logic                       stb_i,
    input  logic                       we_i,
    input  logic [ADDR_W-1:0]          adr_i,
    input  logic [DATA_W-1:0]          dat_i,
    input  logic [DATA_W/LANE_W-1:0]   sel_i,
    output logic [DATA_W-1:0]          dat_o,
    output logic                       ack_o
);

    logic                         ack;
    logic                         done;
    xfer_phase_e                  phase;
    logic [NREGS-1:0]             hit;
    logic [NREGS-1:0][DATA_W-1:0] regs;
    logic                         wr;

    // Acknowledge timing.
    wbs_ack_gen u_ack (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .cyc_i   (cyc_i),
        .stb_i   (stb_i),
        .ack_o   (ack),
        .done_o  (done),
        .phase_o (phase)
    );

    // Address decode.
    wbs_addr_dec #(.ADDR_W(ADDR_W), .NREGS(NREGS)) u_dec (
        .adr_i (adr_i),
        .hit_o (hit)
    );

    // Write only in the completing cycle of a write transfer.
    assign wr = done & we_i & (phase == PH_DONE);

    // Storage.
    wbs_reg_bank #(.DATA_W(DATA_W), .NREGS(NREGS)) u_bank (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .wr_i   (wr),
        .hit_i  (hit),
        .sel_i  (sel_i),
        .dat_i  (dat_i),
        .regs_o (regs)
    );

    // Read path.
    wbs_read_mux #(.DATA_W(DATA_W), .NREGS(NREGS)) u_rd (
        .ack_i  (ack),
        .hit_i  (hit),
        .regs_i (regs),
        .dat_o  (dat_o)
    );

    assign ack_o = ack;

endmodule

// File: rtl/wbs_regbank_chk.sv
// Module: protocol checker for the register slave, bound to the top.
// Relates acknowledge and read data to the bus controls over time.
module wbs_regbank_chk #(
    parameter int unsigned DATA_W = 32
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              cyc_i,
    input logic              stb_i,
    input logic              ack_o,
    input logic [DATA_W-1:0] dat_o
);

    // R1: a fresh request is acknowledged on the next cycle.
    a_r1_ack_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cyc_i && stb_i && !ack_o) |=> ack_o);

    // R2: acknowledge never lasts two cycles.
    a_r2_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_o |=> !ack_o);

    // R3: a dropped strobe gives no acknowledge next cycle.
    a_r3_no_stretch: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !stb_i |=> !ack_o);

    // R8: no acknowledge without a bus cycle.
    a_r8_cyc_gates_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cyc_i |=> !ack_o);

    // R6: read data is zero when not acknowledging.
    a_r6_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ack_o |-> (dat_o == '0));

endmodule

bind wbs_regbank wbs_regbank_chk #(.DATA_W(DATA_W)) u_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cyc_i  (cyc_i),
    .stb_i  (stb_i),
    .ack_o  (ack_o),
    .dat_o  (dat_o)
);

// File: tb/wbs_regbank_tb_top.sv
// Directed bench for the register slave. Inputs change at falling edges;
// outputs are sampled at falling edges or 1 ns after them.
module wbs_regbank_tb_top;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        cyc_i = 1'b0;
    logic        stb_i = 1'b0;
    logic        we_i = 1'b0;
    logic [3:0]  adr_i = '0;
    logic [31:0] dat_i = '0;
    logic [3:0]  sel_i = '0;
    logic [31:0] dat_o;
    logic        ack_o;

    int checks = 0;
    int failures = 0;
    logic [31:0] model [4];

    always #4 clk_i = ~clk_i;

    wbs_regbank dut_i (
        .clk_i (clk_i), .rst_ni (rst_ni), .cyc_i (cyc_i), .stb_i (stb_i),
        .we_i (we_i), .adr_i (adr_i), .dat_i (dat_i), .sel_i (sel_i),
        .dat_o (dat_o), .ack_o (ack_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                          input logic [3:0] sel);
        logic [31:0] r = old;
        for (int b = 0; b < 4; b++) if (sel[b]) r[b*8 +: 8] = nw[b*8 +: 8];
        return r;
    endfunction

    function automatic logic [31:0] expect_rd(input logic [3:0] a);
        return (a < 4) ? model[a[1:0]] : 32'h0;
    endfunction

    // One transfer with cycle dropped afterwards.
    task automatic xfer(input logic w, input logic [3:0] a, input logic [31:0] d,
                        input logic [3:0] s, input string req);
        @(negedge clk_i);
        cyc_i = 1; stb_i = 1; we_i = w; adr_i = a; dat_i = d; sel_i = s;
        #1 chk({req, " R1 wait state"}, {31'h0, ack_o}, 32'h0);
        @(negedge clk_i);
        chk({req, " R1 ack"}, {31'h0, ack_o}, 32'h1);
        if (!w) chk({req, " R6 read"}, dat_o, expect_rd(a));
        @(negedge clk_i);
        chk({req, " R2 single ack"}, {31'h0, ack_o}, 32'h0);
        cyc_i = 0; stb_i = 0; we_i = 0;
        if (w && a < 4) model[a[1:0]] = merge(model[a[1:0]], d, s);
    endtask

    task automatic read_all(input string req);
        for (int a = 0; a < 4; a++) xfer(1'b0, 4'(a), 32'h0, 4'h0, req);
    endtask

    // R4: long cycle with alternate acknowledges.
    task automatic t_long_cycle(input logic w);
        @(negedge clk_i);
        cyc_i = 1; stb_i = 1; we_i = w; sel_i = 4'hF;
        for (int i = 0; i < 6; i++) begin
            logic [3:0] a;
            a = 4'((i * 3) % 4);
            adr_i = a; dat_i = 32'hA500_0000 + 32'(i * 17);
            #1 chk("R4 low between pulses", {31'h0, ack_o}, 32'h0);
            @(negedge clk_i);
            chk("R4 pulse", {31'h0, ack_o}, 32'h1);
            if (!w) chk("R4 read at presented addr", dat_o, expect_rd(a));
            else model[a[1:0]] = dat_i;
            @(negedge clk_i);
        end
        chk("R4 end low", {31'h0, ack_o}, 32'h0);
        cyc_i = 0; stb_i = 0; we_i = 0;
        read_all("R4 readback");
    endtask

    task automatic t_byte_lanes;
        xfer(1'b1, 4'd1, 32'h1122_3344, 4'hF, "R5 full");
        xfer(1'b1, 4'd1, 32'hAABB_CCDD, 4'b0101, "R5 partial");
        xfer(1'b0, 4'd1, 32'h0, 4'h0, "R5 lanes");
        chk("R5 lane model", model[1], 32'h11BB_33DD);
        xfer(1'b1, 4'd3, 32'hFFFF_FFFF, 4'h0, "R5 no lanes");
        xfer(1'b0, 4'd3, 32'h0, 4'h0, "R5 none written");
    endtask

    task automatic t_unmapped;
        xfer(1'b1, 4'd5, 32'hDEAD_BEEF, 4'hF, "R9 write unmapped");
        xfer(1'b1, 4'd12, 32'hCAFE_F00D, 4'hF, "R9 write unmapped");
        xfer(1'b0, 4'd5, 32'h0, 4'h0, "R9 read unmapped");
        read_all("R9 no alias");
    endtask

    task automatic t_glitch;
        @(negedge clk_i);
        cyc_i = 1; stb_i = 1; we_i = 1; adr_i = 4'd2; dat_i = 32'h5555_AAAA; sel_i = 4'hF;
        #2 stb_i = 0; we_i = 0;
        @(negedge clk_i);
        chk("R10 no ack", {31'h0, ack_o}, 32'h0);
        @(negedge clk_i);
        chk("R10 no ack later", {31'h0, ack_o}, 32'h0);
        cyc_i = 0;
        xfer(1'b0, 4'd2, 32'h0, 4'h0, "R10 no write");
    endtask

    task automatic t_no_cyc;
        @(negedge clk_i);
        cyc_i = 0; stb_i = 1; we_i = 1; adr_i = 4'd0; dat_i = 32'h7777_7777; sel_i = 4'hF;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk_i);
            chk("R8 no ack", {31'h0, ack_o}, 32'h0);
            chk("R8 dat zero", dat_o, 32'h0);
        end
        stb_i = 0; we_i = 0;
        xfer(1'b0, 4'd0, 32'h0, 4'h0, "R8 no write");
    endtask

    task automatic t_reset;
        for (int a = 0; a < 4; a++) xfer(1'b1, 4'(a), 32'h0F0F_0000 + 32'(a), 4'hF, "R7 fill");
        @(negedge clk_i);
        cyc_i = 1; stb_i = 1; adr_i = 4'd0; rst_ni = 0;
        @(negedge clk_i);
        chk("R7 ack cleared", {31'h0, ack_o}, 32'h0);
        cyc_i = 0; stb_i = 0;
        @(negedge clk_i);
        rst_ni = 1;
        for (int a = 0; a < 4; a++) model[a] = '0;
        read_all("R7 regs cleared");
    endtask

    initial begin
        for (int a = 0; a < 4; a++) model[a] = '0;
        repeat (3) @(negedge clk_i);
        rst_ni = 1;
        @(negedge clk_i);
        chk("R7 reset ack", {31'h0, ack_o}, 32'h0);
        chk("R6 reset dat", dat_o, 32'h0);
        read_all("R7 reset regs");
        xfer(1'b1, 4'd2, 32'h1234_5678, 4'hF, "R3 write");
        xfer(1'b0, 4'd2, 32'h0, 4'h0, "R3 read");
        t_byte_lanes();
        t_long_cycle(1'b1);
        t_long_cycle(1'b0);
        t_unmapped();
        t_glitch();
        t_no_cyc();
        t_reset();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 8);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule